// File: doc/BRIEF.md
# Smart Card Clock and Bit-Time Generator

This block sits between the interface input clock and the contact card lines. It produces the clock driven to the card by dividing the input clock by a ratio picked with a 3-bit code. It also produces the bit timing (one elementary time unit, ETU) used by the serial byte logic on the I/O line. That timing has two outputs: a tick at the end of each ETU and a strobe in its middle.

The ETU length is a 16-bit count of undivided input clock cycles, split into a low byte and a high byte. The divider does not affect it. Because of this, one ETU can be a non-integer number of card clocks. For example, a count of 112 with divide-by-6 gives about 18.67 card clocks per bit.

The activation logic drives an enable. While the enable is low, the block holds the card clock low, keeps the ETU counter idle, and takes new settings. A receiver can restart the ETU count on a start-bit edge through a resync input. Settings written while the block is running take effect only at safe points, so the card clock never sees a short pulse.

Top module: `sc_clk_etu_gen`

## Requirements
- R1: Divider code 0 to 7 on `div_sel` selects a card clock period of 1, 2, 3, 4, 5, 6, 8 or 16 input cycles, in that order. Code 5 (divide-by-6) is the setting intended for activation.
- R2: For ratios of 2 and above, the card clock is high for ceil(N/2) input cycles and low for floor(N/2). For odd N the high phase is one cycle longer.
- R3: While `clk_en` is low, the card clock is held low and neither `etu_tick` nor `etu_half` is asserted. This holds from the first clock edge after `clk_en` falls.
- R4: A new `div_sel` value is adopted only when a new card clock period begins on a rising edge. The period already in progress finishes with its old high and low lengths.
- R5: With code 0, the card clock is the input clock itself, gated glitch-free by `clk_en`.
- R6: The ETU period P is taken from {`etu_hi`,`etu_lo`} and counted in input cycles, whatever the divider setting. After `clk_en` rises (sample index 0), `etu_tick` is high at index P-1, then again every P cycles.
- R7: A period value of 0 means 65536 cycles. Values 1 to 15 are raised to the 16-cycle minimum.
- R8: `etu_half` is high at count floor(P/2) of each ETU. It is never high in the same cycle as `etu_tick`.
- R9: A `resync` pulse makes the next cycle count 0 of a fresh ETU, using the period value present at that moment.
- R10: A change to the period bytes while the block is running takes effect at the next ETU boundary (after the next tick). The ETU in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Card clock and ETU run enable from activation |
| div_sel | input | 3 | Card clock divider code |
| etu_lo | input | 8 | ETU period, low byte |
| etu_hi | input | 8 | ETU period, high byte |
| resync | input | 1 | Restart the ETU count (start-bit edge) |
| card_clk | output | 1 | Clock to the card |
| etu_tick | output | 1 | One-cycle pulse at the last cycle of each ETU |
| etu_half | output | 1 | One-cycle pulse at the ETU midpoint |

## Verification
Some properties are checked on every cycle: the card clock is quiet and both strobes are silent after the enable drops, and both strobes are silent right after a resync. Every tick and every mid-point strobe must also come at least the minimum ETU length (or half of it) after the last restart, and the two strobes never coincide. Other behaviours can only be shown by the bench's directed scenarios: the exact high and low lengths for each divider code, the full old period before a divider change, the pass-through of divide-by-1, and the exact tick positions. The tick-position scenarios cover the 0 and below-minimum period encodings, resync and a mid-ETU period reload.

// File: rtl/sc_clk_etu_gen.sv
`timescale 1ns/1ps
module sc_clk_etu_gen #(
  parameter int ETU_MIN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic [2:0] div_sel,
  input  logic [7:0] etu_lo,
  input  logic [7:0] etu_hi,
  input  logic       resync,
  output logic       card_clk,
  output logic       etu_tick,
  output logic       etu_half
);

  localparam int PW = 17;

  function automatic logic [4:0] ratio_of(input logic [2:0] c);
    case (c)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2: return 5'd3;
      3'd3: return 5'd4;
      3'd4: return 5'd5;
      3'd5: return 5'd6;
      3'd6: return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // card clock divider
  logic [2:0] cur_sel;
  logic [4:0] dcnt;
  logic       ph_q, gate_q;
  logic [4:0] n_cur, hi_len;
  logic       d_last;

  assign n_cur  = ratio_of(cur_sel);
  assign hi_len = (n_cur + 5'd1) >> 1;
  assign d_last = (dcnt == n_cur - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel <= 3'd0;
      dcnt    <= 5'd0;
      ph_q    <= 1'b0;
    end else if (!clk_en) begin
      cur_sel <= div_sel;
      dcnt    <= ratio_of(div_sel) - 5'd1;
      ph_q    <= 1'b0;
    end else if (d_last) begin
      cur_sel <= div_sel;
      dcnt    <= 5'd0;
      ph_q    <= (div_sel != 3'd0);
    end else begin
      dcnt    <= dcnt + 5'd1;
      ph_q    <= (dcnt + 5'd1) < hi_len;
    end
  end

  // divide-by-1 pass-through, enable changed only while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= clk_en && (cur_sel == 3'd0);
  end

  assign card_clk = ph_q | (clk & gate_q);

  // ETU counter on the undivided clock
  logic [15:0]   raw_p;
  logic [PW-1:0] cfg_p, per_q;
  logic [15:0]   ecnt;

  assign raw_p = {etu_hi, etu_lo};

  always_comb begin
    if (raw_p == 16'd0)              cfg_p = 17'h10000;
    else if (raw_p < 16'(ETU_MIN))   cfg_p = 17'(ETU_MIN);
    else                             cfg_p = {1'b0, raw_p};
  end

  assign etu_tick = ({1'b0, ecnt} == per_q - 17'd1);
  assign etu_half = ({1'b0, ecnt} == (per_q >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt  <= 16'd0;
      per_q <= 17'(ETU_MIN);
    end else if (!clk_en || resync || etu_tick) begin
      ecnt  <= 16'd0;
      per_q <= cfg_p;
    end else begin
      ecnt  <= ecnt + 16'd1;
    end
  end

endmodule

module sc_clk_etu_gen_chk #(
  parameter int ETU_MIN = 16
) (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic resync,
  input logic card_clk,
  input logic etu_tick,
  input logic etu_half
);

  logic [16:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           gap_q <= 17'd0;
    else if (!clk_en || resync || etu_tick) gap_q <= 17'd0;
    else if (gap_q != 17'h1FFFF)          gap_q <= gap_q + 17'd1;
  end

  // R3
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !card_clk);

  // R3
  idle_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (!etu_tick && !etu_half));

  // R9
  resync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && clk_en) |=> (!etu_tick && !etu_half));

  // R7
  tick_min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    etu_tick |-> (gap_q >= 17'(ETU_MIN - 1)));

  // R8
  half_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    etu_half |-> (!etu_tick && gap_q >= 17'(ETU_MIN / 2)));

endmodule

bind sc_clk_etu_gen sc_clk_etu_gen_chk #(.ETU_MIN(ETU_MIN)) u_chk (.*);

// File: tb/sim_sc_clk_etu_gen.sv
`timescale 1ns/1ps
module sim_sc_clk_etu_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [7:0] etu_lo = 8'd0;
  logic [7:0] etu_hi = 8'd0;
  logic       resync = 1'b0;
  logic       card_clk, etu_tick, etu_half;

  int  errs = 0;
  int  nchk = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  sc_clk_etu_gen u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .div_sel(div_sel),
    .etu_lo(etu_lo), .etu_hi(etu_hi), .resync(resync),
    .card_clk(card_clk), .etu_tick(etu_tick), .etu_half(etu_half)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 1; 1: return 2; 2: return 3; 3: return 4;
      4: return 5; 5: return 6; 6: return 8; default: return 16;
    endcase
  endfunction

  task automatic set_period(input int raw);
    {etu_hi, etu_lo} = 16'(raw);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clk_en = 1'b0;
    step; step;
    chk(card_clk === 1'b0, "R3 reset card_clk", card_clk, 0);
    chk(etu_tick === 1'b0, "R3 reset etu_tick", etu_tick, 0);
    chk(etu_half === 1'b0, "R3 reset etu_half", etu_half, 0);
    rst_n = 1'b1;
    step;
  endtask

  task automatic measure(output int hi, output int lo);
    int g = 0;
    while (card_clk !== 1'b0 && g < 100) begin step; g++; end
    while (card_clk !== 1'b1 && g < 200) begin step; g++; end
    hi = 0;
    while (card_clk === 1'b1 && hi < 100) begin hi++; step; end
    lo = 0;
    while (card_clk === 1'b0 && lo < 100) begin lo++; step; end
  endtask

  task automatic t_div(input int code);
    int hi, lo, n;
    clk_en = 1'b0; div_sel = 3'(code);
    step;
    clk_en = 1'b1;
    step;
    measure(hi, lo);
    n = exp_ratio(code);
    chk(hi == (n + 1) / 2, (n % 2) ? "R2 high phase" : "R1 high phase", hi, (n + 1) / 2);
    chk(lo == n / 2, (n % 2) ? "R2 low phase" : "R1 low phase", lo, n / 2);
    clk_en = 1'b0;
    step;
  endtask

  task automatic t_div_change;
    int hi, lo, g;
    clk_en = 1'b0; div_sel = 3'd7;
    step;
    clk_en = 1'b1;
    step;
    g = 0;
    while (card_clk !== 1'b0 && g < 100) begin step; g++; end
    while (card_clk !== 1'b1 && g < 200) begin step; g++; end
    div_sel = 3'd1;
    hi = 0; while (card_clk === 1'b1 && hi < 100) begin hi++; step; end
    lo = 0; while (card_clk === 1'b0 && lo < 100) begin lo++; step; end
    chk(hi == 8, "R4 old period high kept", hi, 8);
    chk(lo == 8, "R4 old period low kept", lo, 8);
    hi = 0; while (card_clk === 1'b1 && hi < 100) begin hi++; step; end
    lo = 0; while (card_clk === 1'b0 && lo < 100) begin lo++; step; end
    chk(hi == 1, "R4 new period high", hi, 1);
    chk(lo == 1, "R4 new period low", lo, 1);
    clk_en = 1'b0;
    step;
  endtask

  task automatic t_bypass;
    clk_en = 1'b0; div_sel = 3'd0;
    step;
    clk_en = 1'b1;
    repeat (3) step;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(card_clk === 1'b1, "R5 follows clk high", card_clk, 1);
      @(negedge clk); #1;
      chk(card_clk === 1'b0, "R5 follows clk low", card_clk, 0);
    end
    clk_en = 1'b0;
    step; step;
    @(posedge clk); #1;
    chk(card_clk === 1'b0, "R5 gated off after disable", card_clk, 0);
    step;
  endtask

  task automatic t_disabled;
    bit bad = 1'b0;
    clk_en = 1'b0; div_sel = 3'd3; set_period(16);
    step;
    clk_en = 1'b1;
    repeat (10) step;
    clk_en = 1'b0;
    step;
    for (int k = 0; k < 40; k++) begin
      if (card_clk !== 1'b0 || etu_tick !== 1'b0 || etu_half !== 1'b0) bad = 1'b1;
      step;
    end
    chk(!bad, "R3 idle outputs quiet", bad, 0);
  endtask

  task automatic t_etu(input int code, input int raw, input int p, input int nlim, input string tag);
    int h1 = -1, t1 = -1, t2 = -1;
    bit both = 1'b0;
    clk_en = 1'b0; div_sel = 3'(code); set_period(raw);
    step;
    clk_en = 1'b1;
    chk(etu_tick === 1'b0 && etu_half === 1'b0, {tag, " index 0 quiet"}, etu_tick, 0);
    for (int k = 1; k <= nlim; k++) begin
      step;
      if (etu_tick && etu_half) both = 1'b1;
      if (etu_half && h1 < 0) h1 = k;
      if (etu_tick) begin
        if (t1 < 0) t1 = k;
        else if (t2 < 0) t2 = k;
      end
    end
    chk(t1 == p - 1, {tag, " first tick"}, t1, p - 1);
    chk(h1 == p / 2, "R8 half strobe position", h1, p / 2);
    chk(!both, "R8 strobes apart", both, 0);
    if (nlim >= 2 * p) chk(t2 == 2 * p - 1, {tag, " second tick"}, t2, 2 * p - 1);
    clk_en = 1'b0;
    step;
  endtask

  task automatic t_resync;
    int h1 = -1, t1 = -1, t2 = -1;
    clk_en = 1'b0; div_sel = 3'd5; set_period(32);
    step;
    clk_en = 1'b1;
    for (int k = 1; k <= 80; k++) begin
      step;
      if (etu_half && h1 < 0) h1 = k;
      if (etu_tick) begin
        if (t1 < 0) t1 = k;
        else if (t2 < 0) t2 = k;
      end
      if (k == 10) resync = 1'b1;
      if (k == 11) resync = 1'b0;
    end
    chk(h1 == 27, "R9 half after resync", h1, 27);
    chk(t1 == 42, "R9 tick after resync", t1, 42);
    chk(t2 == 74, "R9 following tick", t2, 74);
    clk_en = 1'b0;
    step;
  endtask

  task automatic t_reload;
    int h1 = -1, h2 = -1, t1 = -1, t2 = -1;
    clk_en = 1'b0; div_sel = 3'd6; set_period(20);
    step;
    clk_en = 1'b1;
    for (int k = 1; k <= 100; k++) begin
      step;
      if (etu_half) begin
        if (h1 < 0) h1 = k;
        else if (h2 < 0) h2 = k;
      end
      if (etu_tick) begin
        if (t1 < 0) t1 = k;
        else if (t2 < 0) t2 = k;
      end
      if (k == 5) set_period(40);
    end
    chk(h1 == 10, "R10 old half kept", h1, 10);
    chk(t1 == 19, "R10 old length kept", t1, 19);
    chk(h2 == 40, "R10 new half", h2, 40);
    chk(t2 == 59, "R10 new length", t2, 59);
    clk_en = 1'b0;
    step;
  endtask

  initial begin
    t_reset;
    for (int c = 1; c < 8; c++) t_div(c);
    t_div_change;
    t_bypass;
    t_disabled;
    t_etu(5, 112, 112, 240, "R6");
    t_etu(6, 149, 149, 310, "R6");
    t_etu(2, 33, 33, 80, "R8");
    t_etu(3, 5, 16, 40, "R7");
    t_etu(3, 16, 16, 40, "R7");
    t_etu(3, 0, 65536, 65540, "R7");
    t_resync;
    t_reload;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      errs++; nchk++;
      $display("FAIL watchdog (R1..R10 run incomplete): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

endmodule